// File: doc/BRIEF.md
# Parallel Flash Page Write Controller

This controller sits on the host side of a byte-wide, 5 V-only parallel flash with a 15-bit address. It writes one 64-byte page per command. A start command supplies a page-aligned address. The controller then takes 64 bytes from a valid/ready stream and places each one on the flash bus with a single write-enable low pulse. During each pulse chip-enable is held low and output-enable high. The write-enable low time and the recovery time between pulses come from cycle-count parameters.

Once the last byte is latched, the flash erases and programs the page without further help. While it does so, the controller releases the data bus. At a fixed interval it reads back the last address written and compares data bit 7 with the true bit 7 of the last byte. When the two agree, the controller raises a one-cycle done pulse. If they never agree within a bounded time, it sets a sticky timeout flag instead.

The flash starts its program cycle by itself when the gap between two byte writes grows too long. For this reason the controller bounds how long the upstream source may hold valid low inside the page-load window. A source that stalls too long is flagged with an error, and the controller goes on to poll whatever bytes the flash has already taken.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, busy_o, done_o, in_ready_o and all error flags are low, and the three flash strobes (chip-enable, output-enable, write-enable, all active low) are high.
- R2: A start_i seen while idle with start_addr_i bits [5:0] not zero sets align_err_o. No flash strobe is driven and busy_o stays low. The next accepted start clears align_err_o.
- R3: Flash address bits [14:6] equal start_addr_i[14:6] for every byte written. Bits [5:0] count 0, 1, ... 63 in write order. The byte on flash_dq_o at each write-enable rising edge is the next byte taken from the input stream.
- R4: Every write-enable low pulse lasts exactly WE_LOW_CYC cycles. During the pulse chip-enable is low, output-enable is high, the data bus is driven, and address and data stay stable. Consecutive pulses are separated by at least WE_HIGH_CYC cycles.
- R5: in_ready_o is high only while the controller waits for the next byte of a page. Each handshake (in_valid_i and in_ready_o both high at a rising clock edge) produces exactly one byte write.
- R6: Once at least one byte is written, GAP_LIMIT_CYC consecutive waiting cycles with in_valid_i low set the sticky gap_err_o. No further bytes are taken, and completion polling begins. GAP_LIMIT_CYC-1 such cycles cause no error.
- R7: After the last write, the controller releases the data bus (flash_dq_oe_o low). Each poll is a read of the last written address with chip-enable and output-enable low for RD_CYC cycles. Reads are separated by POLL_INT_CYC cycles with all strobes high.
- R8: A poll whose sampled bit 7 equals bit 7 of the last written byte ends the operation. In the same cycle done_o is high for exactly one cycle and busy_o falls. With an immediately ready flash, done_o appears WE_HIGH_CYC+POLL_INT_CYC+RD_CYC cycles after the last write-enable rising edge.
- R9: If no poll matches within TIMEOUT_CYC cycles of polling, timeout_o is set and busy_o falls with no done pulse. This is exactly WE_HIGH_CYC+TIMEOUT_CYC cycles after the last write-enable rising edge. The next accepted start clears timeout_o.
- R10: start_i while busy_o is high has no effect: the running page and all flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page write |
| start_addr_i | input | 15 | Page start address, must be 64-byte aligned |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Controller takes a byte this cycle when valid |
| flash_addr_o | output | 15 | Flash address bus |
| flash_dq_o | output | 8 | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_dq_i | input | 8 | Flash read data |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| busy_o | output | 1 | Page write or polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky polling timeout |
| align_err_o | output | 1 | Sticky misaligned start |
| gap_err_o | output | 1 | Sticky input stall beyond the gap limit |

## Verification
The hardest case to reach from the ports is the gap limit at its exact boundary. The stall is measured only in cycles where the controller is waiting and has already written a byte, so a simple idle period on the input does not reach it. The bench's stream driver counts ready-high cycles per byte and holds valid low for a chosen number of them. One run sits one cycle under the limit on every byte. Another reaches the limit exactly in the middle of a page, so the error and the early switch to polling can be checked against the number of bytes written. A behavioural flash model inverts bit 7 for a set number of cycles after the last write. This lets the runs cover immediate completion, long busy periods and a busy period longer than the timeout.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WE_LO,
    ST_WE_HI,
    ST_POLL_GAP,
    ST_POLL_RD
  } fpw_state_e;
endpackage

// File: rtl/fpw_timer.sv
module fpw_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/fpw_bus.sv
module fpw_bus
  import fpw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  fpw_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no
);
  always_comb begin
    ce_no   = 1'b1;
    oe_no   = 1'b1;
    we_no   = 1'b1;
    dq_oe_o = 1'b0;
    unique case (state_i)
      ST_LOAD:    ce_no = 1'b0;
      ST_WE_LO: begin
        ce_no   = 1'b0;
        we_no   = 1'b0;
        dq_oe_o = 1'b1;
      end
      ST_WE_HI: begin
        ce_no   = 1'b0;
        dq_oe_o = 1'b1;
      end
      ST_POLL_RD: begin
        ce_no = 1'b0;
        oe_no = 1'b0;
      end
      default: ;
    endcase
  end

  assign addr_o = (state_i == ST_IDLE) ? '0 : addr_i;
  assign dq_o   = dq_oe_o ? data_i : '0;
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 64,
  parameter int CNT_W         = 32,
  parameter int WE_LOW_CYC    = 4,
  parameter int WE_HIGH_CYC   = 3,
  parameter int GAP_LIMIT_CYC = 7500,
  parameter int POLL_INT_CYC  = 50,
  parameter int RD_CYC        = 4,
  parameter int TIMEOUT_CYC   = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              flash_ce_no,
  output logic              flash_oe_no,
  output logic              flash_we_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              align_err_o,
  output logic              gap_err_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int NUM_W  = OFS_W + 1;
  localparam int MSB    = DATA_W - 1;

  fpw_state_e         state_q, state_d;
  logic [PAGE_W-1:0]  page_q;
  logic [OFS_W-1:0]   ofs_q;
  logic [NUM_W-1:0]   num_q;
  logic [DATA_W-1:0]  data_q;
  logic               msb_q;
  logic               align_q, gap_q, to_q, done_q;
  logic [CNT_W-1:0]   ph_lim;
  logic               ph_hit, to_hit, in_poll;
  logic               start_ok, start_bad, take, gap_trip, match, fin_ok, fin_to;
  logic [MSB-1:0]     unused_dq;

  assign unused_dq = flash_dq_i[MSB-1:0];
  assign in_poll   = (state_q == ST_POLL_GAP) || (state_q == ST_POLL_RD);
  assign start_ok  = (state_q == ST_IDLE) && start_i && (start_addr_i[OFS_W-1:0] == '0);
  assign start_bad = (state_q == ST_IDLE) && start_i && (start_addr_i[OFS_W-1:0] != '0);
  assign take      = (state_q == ST_LOAD) && in_valid_i;
  assign gap_trip  = (state_q == ST_LOAD) && !in_valid_i && (num_q != '0) && ph_hit;
  assign match     = (flash_dq_i[MSB] == msb_q);
  assign fin_ok    = (state_q == ST_POLL_RD) && ph_hit && match;
  assign fin_to    = in_poll && to_hit && !fin_ok;

  always_comb begin
    unique case (state_q)
      ST_LOAD:     ph_lim = CNT_W'(GAP_LIMIT_CYC);
      ST_WE_LO:    ph_lim = CNT_W'(WE_LOW_CYC);
      ST_WE_HI:    ph_lim = CNT_W'(WE_HIGH_CYC);
      ST_POLL_GAP: ph_lim = CNT_W'(POLL_INT_CYC);
      ST_POLL_RD:  ph_lim = CNT_W'(RD_CYC);
      default:     ph_lim = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_LOAD;
      ST_LOAD: begin
        if (in_valid_i)    state_d = ST_WE_LO;
        else if (gap_trip) state_d = ST_POLL_GAP;
      end
      ST_WE_LO: if (ph_hit) state_d = ST_WE_HI;
      ST_WE_HI: if (ph_hit)
        state_d = (num_q == NUM_W'(PAGE_BYTES)) ? ST_POLL_GAP : ST_LOAD;
      ST_POLL_GAP: begin
        if (fin_to)      state_d = ST_IDLE;
        else if (ph_hit) state_d = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        if (fin_ok || fin_to) state_d = ST_IDLE;
        else if (ph_hit)      state_d = ST_POLL_GAP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ofs_q   <= '0;
      num_q   <= '0;
      data_q  <= '0;
      msb_q   <= 1'b0;
      align_q <= 1'b0;
      gap_q   <= 1'b0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok;
      if (start_ok) begin
        page_q  <= start_addr_i[ADDR_W-1:OFS_W];
        num_q   <= '0;
        align_q <= 1'b0;
        gap_q   <= 1'b0;
        to_q    <= 1'b0;
      end
      if (start_bad) align_q <= 1'b1;
      if (take) begin
        data_q <= in_data_i;
        msb_q  <= in_data_i[MSB];
        ofs_q  <= num_q[OFS_W-1:0];
        num_q  <= num_q + 1'b1;
      end
      if (gap_trip) gap_q <= 1'b1;
      if (fin_to)   to_q  <= 1'b1;
    end
  end

  fpw_timer #(.CNT_W(CNT_W)) u_phase_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .en_i   (state_q != ST_IDLE),
    .limit_i(ph_lim),
    .hit_o  (ph_hit)
  );

  fpw_timer #(.CNT_W(CNT_W)) u_poll_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .en_i   (in_poll),
    .limit_i(CNT_W'(TIMEOUT_CYC)),
    .hit_o  (to_hit)
  );

  fpw_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .state_i(state_q),
    .addr_i ({page_q, ofs_q}),
    .data_i (data_q),
    .addr_o (flash_addr_o),
    .dq_o   (flash_dq_o),
    .dq_oe_o(flash_dq_oe_o),
    .ce_no  (flash_ce_no),
    .oe_no  (flash_oe_no),
    .we_no  (flash_we_no)
  );

  assign in_ready_o  = (state_q == ST_LOAD);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = to_q;
  assign align_err_o = align_q;
  assign gap_err_o   = gap_q;

  assert_we_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> (!flash_ce_no && flash_oe_no && flash_dq_oe_o));
  assert_we_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));
  assert_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (busy_o && flash_we_no && flash_oe_no));
  assert_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gap_err_o) |-> (busy_o && !in_ready_o));
  assert_read_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> (!flash_dq_oe_o && flash_we_no && !flash_ce_no));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !timeout_o));
  assert_timeout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!busy_o && !done_o));
  assert_align_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(align_err_o));
endmodule

// File: tb/flash_page_writer_tb.sv
module flash_page_writer_tb;
  localparam int WL  = 2;
  localparam int WH  = 2;
  localparam int GAP = 12;
  localparam int PI  = 5;
  localparam int RD  = 3;
  localparam int TO  = 300;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] start_addr_i = '0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o;
  logic [14:0] flash_addr_o;
  logic [7:0]  flash_dq_o;
  logic        flash_dq_oe_o;
  logic [7:0]  flash_dq_i;
  logic        flash_ce_no, flash_oe_no, flash_we_no;
  logic        busy_o, done_o, timeout_o, align_err_o, gap_err_o;

  flash_page_writer #(
    .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .GAP_LIMIT_CYC(GAP),
    .POLL_INT_CYC(PI), .RD_CYC(RD), .TIMEOUT_CYC(TO)
  ) u_dut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // run configuration
  int cur_pg = 0, cur_m = 0, cur_sm = 0, cur_gat = 0, busy_cyc = 0;
  bit drv_en = 0;

  // model and monitor state
  logic [7:0] pb [64];
  logic [7:0] last_d = '0;
  bit  prog = 0, busy_m = 0, we_prev = 1, oe_prev = 1, to_seen = 0;
  int  wr_cnt = 0, rise_cyc = 0, we_lo_len = 0, we_hi_len = 0;
  int  rd_len = 0, gap_len = 0, n_reads = 0, done_cnt = 0, done_cyc = 0, to_cyc = 0;
  int  v_frame = 0, v_wl = 0, v_wh = 0, v_addr = 0, v_rd = 0, v_gap = 0, v_rdaddr = 0;
  int  hs_cnt = 0, seen = 0, wc = 0;

  function automatic logic [7:0] pat(int pg, int m, int i);
    return 8'(i * (2 * m + 1) + pg * 13 + m * 37);
  endfunction

  function automatic int stall(int i);
    case (cur_sm)
      1: return (i * 7) % GAP;
      2: return GAP - 1;
      3: return (i == cur_gat) ? GAP : 0;
      default: return 0;
    endcase
  endfunction

  assign flash_dq_i = (!flash_ce_no && !flash_oe_no)
                      ? (busy_m ? {~last_d[7], last_d[6:0]} : pb[flash_addr_o[5:0]]) : 8'h00;

  always @(posedge clk_i) if (in_valid_i && in_ready_o) hs_cnt <= hs_cnt + 1;

  always @(negedge clk_i) begin
    if (hs_cnt != seen) begin
      seen = hs_cnt;
      in_valid_i = 1'b0;
      wc = 0;
    end
    if (drv_en && in_ready_o && !in_valid_i && hs_cnt < 64) begin
      if (wc >= stall(hs_cnt)) begin
        in_valid_i = 1'b1;
        in_data_i  = pat(cur_pg, cur_m, hs_cnt);
      end else wc++;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    if (!flash_we_no) begin
      if (flash_ce_no || !flash_oe_no) v_frame++;
      if (we_prev) begin
        if (wr_cnt > 0 && we_hi_len < WH) v_wh++;
        we_lo_len = 1;
      end else we_lo_len++;
    end else if (!we_prev) begin
      if (we_lo_len != WL) v_wl++;
      if (flash_addr_o[14:6] != 9'(cur_pg)) v_addr++;
      if (flash_addr_o[5:0] != 6'(wr_cnt)) v_addr++;
      pb[flash_addr_o[5:0]] = flash_dq_o;
      last_d = flash_dq_o;
      wr_cnt++;
      rise_cyc = cyc;
      prog = 1;
      we_hi_len = 1;
    end else we_hi_len++;
    we_prev = flash_we_no;

    if (!flash_oe_no) begin
      if (flash_addr_o != {9'(cur_pg), 6'(wr_cnt - 1)}) v_rdaddr++;
      if (oe_prev) begin
        if (n_reads > 0 && gap_len != PI) v_gap++;
        rd_len = 1;
      end else rd_len++;
    end else if (!oe_prev) begin
      if (rd_len != RD) v_rd++;
      n_reads++;
      gap_len = 1;
    end else gap_len++;
    oe_prev = flash_oe_no;

    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
    if (timeout_o && !to_seen) begin
      to_seen = 1;
      to_cyc = cyc;
    end
    busy_m = prog && ((cyc - rise_cyc) < busy_cyc);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_page(int pg, int m, int bsy, int sm, int gat, bit inj, bit exp_to);
    int nexp, bad, t0;
    nexp = (sm == 3) ? gat : 64;
    @(negedge clk_i);
    for (int i = 0; i < 64; i++) pb[i] = 8'hFF;
    cur_pg = pg; cur_m = m; cur_sm = sm; cur_gat = gat; busy_cyc = bsy;
    wr_cnt = 0; prog = 0; busy_m = 0; n_reads = 0; done_cnt = 0; to_seen = 0;
    v_frame = 0; v_wl = 0; v_wh = 0; v_addr = 0; v_rd = 0; v_gap = 0; v_rdaddr = 0;
    hs_cnt = 0; seen = 0; wc = 0; drv_en = 1;
    start_addr_i = {9'(pg), 6'd0};
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !timeout_o && !align_err_o, "R9 start clears flags", timeout_o, 0);
    t0 = cyc;
    fork
      while (busy_o && cyc - t0 < 20000) @(negedge clk_i);
      if (inj) begin
        repeat (30) @(negedge clk_i);
        start_addr_i = {9'(3), 6'd7};
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        start_addr_i = '0;
      end
    join
    drv_en = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R8 operation ends", busy_o, 0);
    chk(wr_cnt == nexp && hs_cnt == nexp, "R5 one write per handshake", wr_cnt, nexp);
    bad = 0;
    for (int i = 0; i < nexp; i++) if (pb[i] !== pat(pg, m, i)) bad++;
    chk(bad == 0 && v_addr == 0, "R3 address order and data", bad + v_addr, 0);
    chk(v_frame == 0 && v_wl == 0 && v_wh == 0, "R4 strobe timing",
        v_frame + v_wl + v_wh, 0);
    chk(n_reads > 0 && v_rd == 0 && v_gap == 0 && v_rdaddr == 0, "R7 poll reads",
        v_rd + v_gap + v_rdaddr, 0);
    chk(gap_err_o == (sm == 3), "R6 gap flag", gap_err_o, sm == 3);
    chk(!in_ready_o, "R5 ready low when idle", in_ready_o, 0);
    if (inj) chk(!align_err_o, "R10 start while busy ignored", align_err_o, 0);
    if (exp_to) begin
      chk(timeout_o && done_cnt == 0, "R9 timeout without done", done_cnt, 0);
      chk(to_cyc == rise_cyc + WH + TO, "R9 timeout cycle", to_cyc - rise_cyc, WH + TO);
    end else begin
      chk(!timeout_o && done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      chk(done_cyc >= rise_cyc + bsy &&
          done_cyc <= rise_cyc + bsy + WH + 2 * (PI + RD) + 2,
          "R8 done latency", done_cyc - rise_cyc, bsy);
      if (bsy == 0)
        chk(done_cyc == rise_cyc + WH + PI + RD, "R8 exact done cycle",
            done_cyc - rise_cyc, WH + PI + RD);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !in_ready_o && !timeout_o && !align_err_o && !gap_err_o,
        "R1 reset outputs", busy_o, 0);
    chk(flash_ce_no && flash_oe_no && flash_we_no, "R1 reset strobes", flash_we_no, 1);

    start_addr_i = 15'h0045;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(align_err_o && !busy_o, "R2 misaligned rejected", align_err_o, 1);
    chk(flash_we_no && flash_ce_no && !in_ready_o, "R2 no strobes", flash_ce_no, 1);

    run_page(0, 0, 0, 0, 0, 0, 0);
    chk(!align_err_o, "R2 cleared by next start", align_err_o, 0);
    run_page(1, 1, 40, 1, 0, 0, 0);
    run_page(511, 2, 150, 2, 0, 0, 0);
    run_page(37, 3, 60, 0, 0, 1, 0);
    run_page(200, 4, 20, 3, 10, 0, 0);
    run_page(300, 5, 1000, 0, 0, 0, 1);
    repeat (900) @(negedge clk_i);
    run_page(5, 6, 10, 1, 0, 0, 0);
    chk(!timeout_o, "R9 timeout cleared", timeout_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule